// File: doc/BRIEF.md
# Configuration lock key sequencer

This block guards the pin configuration of a 16-pin port. Software arms the guard by making three full 32-bit writes to the lock register. The key bit (bit 16) must go 1, then 0, then 1. The low sixteen bits carry the pin mask and must not change across the three writes. When the third write matches, the key flag latches and the pin mask freezes. Both stay that way until the next reset.

While the key flag is clear, the pin mask is an ordinary register: any write updates it, honouring byte lanes 0 and 1. Once the key is active, the latched mask drives a per-pin lock vector. It also drives five write-enable filters, one for each configuration field group. The filters clear the enable bits belonging to locked pins before those enables reach the configuration registers. Pin p owns bits [p*W +: W] of a group whose field width is W.

The register reads back as the mask in bits 15:0, the key flag in bit 16 and zeros above. Reads have no side effect, because the read value is a plain combinational view of the state.

Top module: `cfglk_top`

## Requirements
- R1: After reset the key flag is 0, the lock mask is 0, the read value is 0, and every filter passes its enable bits through unchanged.
- R2: Three full-word writes in order, with bit 16 equal to 1, then 0, then 1, and an identical bits 15:0 value, set the key flag. The flag and bit 16 of the read value go to 1 in the cycle after the third write. Cycles without a write may separate the three writes.
- R3: If bits 15:0 of the second or third write differ from those of the first, the attempt fails, and the key flag stays 0.
- R4: A full-word write with bit 16 = 0 while the sequencer is waiting for the third write aborts the attempt and returns the sequencer to idle.
- R5: A write with byte enables other than 4'b1111 never advances the sequence. If it arrives while an attempt is pending, it aborts that attempt.
- R6: A full-word write with bit 16 = 1 that does not continue a pending attempt restarts the sequence at step one, taking that write's bits 15:0 as the new mask.
- R7: While the key flag is 0, a write updates mask bits 7:0 when byte enable 0 is set and bits 15:8 when byte enable 1 is set. Read bits 31:17 are always 0.
- R8: Once the key flag is 1, no write changes the flag or the mask.
- R9: For each pin whose lock bit is set, the filtered enables of that pin are 0 in all five groups: mode (2 bits per pin), output type (1), speed (2), pull (2) and alternate function (4). Enables of unlocked pins pass through unchanged.
- R10: Asserting reset clears the key flag and the mask, which ends a lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_wr | input | 1 | Write strobe for the lock register |
| lk_be | input | 4 | Byte enables of the write; 4'b1111 is a full-word access |
| lk_wdata | input | 32 | Write data; bit 16 is the key bit, bits 15:0 the pin mask |
| lk_rdata | output | 32 | Read value: {15'b0, key, mask} |
| key_active | output | 1 | Lock key latched |
| pin_lock | output | 16 | Per-pin lock vector |
| mode_we_i | input | 32 | Mode field write enables, 2 per pin |
| otype_we_i | input | 16 | Output-type field write enables, 1 per pin |
| speed_we_i | input | 32 | Speed field write enables, 2 per pin |
| pull_we_i | input | 32 | Pull field write enables, 2 per pin |
| af_we_i | input | 64 | Alternate-function field write enables, 4 per pin |
| mode_we_o | output | 32 | Filtered mode enables |
| otype_we_o | output | 16 | Filtered output-type enables |
| speed_we_o | output | 32 | Filtered speed enables |
| pull_we_o | output | 32 | Filtered pull enables |
| af_we_o | output | 64 | Filtered alternate-function enables |

## Verification
Each write updates the key flag, the mask and the read value at the very next rising edge. The filter outputs are combinational from the registered mask and the present enable inputs, so they reflect that new mask in the same cycle. The bench therefore drives one stimulus per cycle on the falling edge and queues the expected values for that cycle. It compares them a quarter period after the following rising edge, when both the registered and the combinational results have settled. Reset release passes through a two-stage synchronizer, so the bench leaves three write-free cycles after releasing reset before the first write.

// File: rtl/cfglk_pkg.sv
package cfglk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GOT1   = 2'd1,
    ST_GOT2   = 2'd2,
    ST_LOCKED = 2'd3
  } seq_state_e;
endpackage

// File: rtl/cfglk_rst_sync.sv
module cfglk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/cfglk_key_fsm.sv
module cfglk_key_fsm
  import cfglk_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   wdata,
  output logic                key_active
);
  localparam int BE_W = DATA_W / 8;

  seq_state_e       state_q, state_n;
  logic [NPINS-1:0] cand_q, cand_n;
  logic             cand_en;
  logic             full_acc, key_bit, same_mask;

  assign full_acc  = (be == {BE_W{1'b1}});
  assign key_bit   = wdata[NPINS];
  assign same_mask = (wdata[NPINS-1:0] == cand_q);

  // Next-state logic
  always_comb begin
    state_n = state_q;
    cand_n  = cand_q;
    cand_en = 1'b0;
    if (wr) begin
      case (state_q)
        ST_IDLE: begin
          if (full_acc && key_bit) begin
            state_n = ST_GOT1;
            cand_n  = wdata[NPINS-1:0];
            cand_en = 1'b1;
          end
        end
        ST_GOT1: begin
          if (full_acc && key_bit) begin
            state_n = ST_GOT1;
            cand_n  = wdata[NPINS-1:0];
            cand_en = 1'b1;
          end else if (full_acc && !key_bit && same_mask) begin
            state_n = ST_GOT2;
          end else begin
            state_n = ST_IDLE;
          end
        end
        ST_GOT2: begin
          if (full_acc && key_bit && same_mask) begin
            state_n = ST_LOCKED;
          end else if (full_acc && key_bit) begin
            state_n = ST_GOT1;
            cand_n  = wdata[NPINS-1:0];
            cand_en = 1'b1;
          end else begin
            state_n = ST_IDLE;
          end
        end
        default: state_n = ST_LOCKED;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cand_q  <= '0;
    end else begin
      state_q <= state_n;
      if (cand_en) cand_q <= cand_n;
    end
  end

  assign key_active = (state_q == ST_LOCKED);

  // R8: the key flag never drops while out of reset
  assert_key_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    key_active |=> key_active);

  // R2: the key only rises right after a full-word write with key bit 1
  assert_key_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_active) |-> $past(wr && (be == {BE_W{1'b1}}) && wdata[NPINS]));

  // R3: the second step is only reached with a matching mask
  assert_got2_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_GOT2) |-> ($past(state_q) == ST_GOT1) &&
                                  $past(wdata[NPINS-1:0] == cand_q));

  // R5: a partial access never moves the sequence forward
  assert_partial_no_adv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (be != {BE_W{1'b1}}) && (state_q != ST_LOCKED)) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/cfglk_mask_reg.sv
module cfglk_mask_reg #(
  parameter int NPINS  = 16,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                key_active,
  output logic [NPINS-1:0]    lock_mask
);
  logic [NPINS-1:0] mask_q, mask_n, bit_en;

  // Per-bit enable from its byte lane, blocked once the key is active
  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    localparam int LANE = i / 8;
    always_comb begin
      bit_en[i] = wr && !key_active && be[LANE];
      mask_n[i] = wdata[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q[i] <= 1'b0;
      else if (bit_en[i]) mask_q[i] <= mask_n[i];
    end
  end

  assign lock_mask = mask_q;

  // R8: mask frozen while locked
  assert_mask_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    key_active |=> $stable(lock_mask));
endmodule

// File: rtl/cfglk_field_filter.sv
module cfglk_field_filter #(
  parameter int NPINS = 16,
  parameter int FW    = 2
) (
  input  logic [NPINS-1:0]    lock_mask,
  input  logic [NPINS*FW-1:0] we_in,
  output logic [NPINS*FW-1:0] we_out
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign we_out[p*FW +: FW] = lock_mask[p] ? {FW{1'b0}} : we_in[p*FW +: FW];
  end
endmodule

// File: rtl/cfglk_top.sv
module cfglk_top #(
  parameter int NPINS   = 16,
  parameter int DATA_W  = 32,
  parameter int MODE_W  = 2,
  parameter int OTYPE_W = 1,
  parameter int SPEED_W = 2,
  parameter int PULL_W  = 2,
  parameter int AF_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_wr,
  input  logic [DATA_W/8-1:0]      lk_be,
  input  logic [DATA_W-1:0]        lk_wdata,
  output logic [DATA_W-1:0]        lk_rdata,
  output logic                     key_active,
  output logic [NPINS-1:0]         pin_lock,
  input  logic [NPINS*MODE_W-1:0]  mode_we_i,
  input  logic [NPINS*OTYPE_W-1:0] otype_we_i,
  input  logic [NPINS*SPEED_W-1:0] speed_we_i,
  input  logic [NPINS*PULL_W-1:0]  pull_we_i,
  input  logic [NPINS*AF_W-1:0]    af_we_i,
  output logic [NPINS*MODE_W-1:0]  mode_we_o,
  output logic [NPINS*OTYPE_W-1:0] otype_we_o,
  output logic [NPINS*SPEED_W-1:0] speed_we_o,
  output logic [NPINS*PULL_W-1:0]  pull_we_o,
  output logic [NPINS*AF_W-1:0]    af_we_o
);
  localparam int RSV_W = DATA_W - NPINS - 1;

  logic             rst_n_sync;
  logic             key_q;
  logic [NPINS-1:0] mask_q;

  cfglk_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  cfglk_key_fsm #(.NPINS(NPINS), .DATA_W(DATA_W)) u_key_fsm (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .wr         (lk_wr),
    .be         (lk_be),
    .wdata      (lk_wdata),
    .key_active (key_q)
  );

  cfglk_mask_reg #(.NPINS(NPINS), .DATA_W(DATA_W)) u_mask_reg (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .wr         (lk_wr),
    .be         (lk_be),
    .wdata      (lk_wdata),
    .key_active (key_q),
    .lock_mask  (mask_q)
  );

  // Lock applies only once the key is latched
  assign pin_lock   = key_q ? mask_q : '0;
  assign key_active = key_q;
  assign lk_rdata   = {{RSV_W{1'b0}}, key_q, mask_q};

  cfglk_field_filter #(.NPINS(NPINS), .FW(MODE_W)) u_flt_mode (
    .lock_mask (pin_lock), .we_in (mode_we_i), .we_out (mode_we_o));
  cfglk_field_filter #(.NPINS(NPINS), .FW(OTYPE_W)) u_flt_otype (
    .lock_mask (pin_lock), .we_in (otype_we_i), .we_out (otype_we_o));
  cfglk_field_filter #(.NPINS(NPINS), .FW(SPEED_W)) u_flt_speed (
    .lock_mask (pin_lock), .we_in (speed_we_i), .we_out (speed_we_o));
  cfglk_field_filter #(.NPINS(NPINS), .FW(PULL_W)) u_flt_pull (
    .lock_mask (pin_lock), .we_in (pull_we_i), .we_out (pull_we_o));
  cfglk_field_filter #(.NPINS(NPINS), .FW(AF_W)) u_flt_af (
    .lock_mask (pin_lock), .we_in (af_we_i), .we_out (af_we_o));

  // R7: reserved read bits stay zero
  assert_rsv_zero_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    lk_rdata[DATA_W-1:NPINS+1] == '0);

  // R9: no output-type enable escapes for a locked pin
  assert_otype_gate_R9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (otype_we_o & pin_lock) == '0);
endmodule

// File: tb/cfglk_top_tb.sv
module cfglk_top_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          req;
    logic        key;
    logic [15:0] mask;
    logic [31:0] pat;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_wr = 1'b0;
  logic [3:0]  lk_be = 4'h0;
  logic [31:0] lk_wdata = '0;
  logic [31:0] lk_rdata;
  logic        key_active;
  logic [15:0] pin_lock;
  logic [31:0] mode_i = '0, speed_i = '0, pull_i = '0;
  logic [15:0] otype_i = '0;
  logic [63:0] af_i = '0;
  logic [31:0] mode_o, speed_o, pull_o;
  logic [15:0] otype_o;
  logic [63:0] af_o;

  int checks = 0;
  int failures = 0;
  exp_t sb_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfglk_top u_dut (
    .clk (clk), .rst_n (rst_n),
    .lk_wr (lk_wr), .lk_be (lk_be), .lk_wdata (lk_wdata), .lk_rdata (lk_rdata),
    .key_active (key_active), .pin_lock (pin_lock),
    .mode_we_i (mode_i), .otype_we_i (otype_i), .speed_we_i (speed_i),
    .pull_we_i (pull_i), .af_we_i (af_i),
    .mode_we_o (mode_o), .otype_we_o (otype_o), .speed_we_o (speed_o),
    .pull_we_o (pull_o), .af_we_o (af_o)
  );

  function automatic logic [63:0] spread(input logic [15:0] m, input int w);
    logic [63:0] r = '0;
    for (int p = 0; p < 16; p++)
      for (int b = 0; b < w; b++) r[p*w + b] = m[p];
    return r;
  endfunction

  // One cycle of stimulus, with the expected state after the next edge
  task automatic step(input logic wr, input logic [3:0] be, input logic [31:0] d,
                      input logic ek, input logic [15:0] em, input int req,
                      input logic [31:0] pat);
    exp_t e;
    @(negedge clk);
    lk_wr = wr; lk_be = be; lk_wdata = d;
    mode_i = pat; otype_i = pat[15:0]; speed_i = ~pat; pull_i = pat;
    af_i = {pat, ~pat};
    e.req = req; e.key = ek; e.mask = em; e.pat = pat;
    sb_q.push_back(e);
  endtask

  task automatic wr_full(input logic k, input logic [15:0] m,
                         input logic ek, input logic [15:0] em, input int req);
    step(1'b1, 4'hF, {15'd0, k, m}, ek, em, req, {m, ~m} ^ 32'h5A3C_96E1);
  endtask

  // Monitor: compares each queued expectation a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        exp_t e;
        logic [31:0] exp_rd;
        logic [15:0] lk;
        logic [63:0] l2, l1, l4;
        e = sb_q.pop_front();
        exp_rd = {15'd0, e.key, e.mask};
        lk = e.key ? e.mask : 16'h0;
        checks++;
        if (lk_rdata !== exp_rd || key_active !== e.key || pin_lock !== lk) begin
          failures++;
          $display("FAIL R%0d: rdata=%h key=%b lock=%h expected rdata=%h key=%b lock=%h",
                   e.req, lk_rdata, key_active, pin_lock, exp_rd, e.key, lk);
        end
        // R9: filters clear enables of locked pins
        l2 = spread(lk, 2); l1 = spread(lk, 1); l4 = spread(lk, 4);
        checks++;
        if (mode_o  !== (e.pat & ~l2[31:0]) ||
            otype_o !== (e.pat[15:0] & ~l1[15:0]) ||
            speed_o !== (~e.pat & ~l2[31:0]) ||
            pull_o  !== (e.pat & ~l2[31:0]) ||
            af_o    !== ({e.pat, ~e.pat} & ~l4)) begin
          failures++;
          $display("FAIL R9: mode=%h af=%h expected mode=%h af=%h",
                   mode_o, af_o, e.pat & ~l2[31:0], {e.pat, ~e.pat} & ~l4);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state, filters pass everything
    step(1'b0, 4'h0, '0, 1'b0, 16'h0, 1, 32'hFFFF_FFFF);
    rst_n = 1'b1;
    step(1'b0, 4'h0, '0, 1'b0, 16'h0, 1, 32'hFFFF_FFFF);
    step(1'b0, 4'h0, '0, 1'b0, 16'h0, 1, 32'hA5A5_5A5A);
    step(1'b0, 4'h0, '0, 1'b0, 16'h0, 1, 32'h1234_5678);
    // R7: byte-lane mask writes, reserved bits read zero
    step(1'b1, 4'b0001, 32'h0001_00A5, 1'b0, 16'h00A5, 7, 32'hFFFF_FFFF);
    step(1'b1, 4'b0010, 32'h0000_3C00, 1'b0, 16'h3CA5, 7, 32'hFFFF_FFFF);
    step(1'b1, 4'hF,    32'hFFFE_0000, 1'b0, 16'h0000, 7, 32'hFFFF_FFFF);
    // R3: mismatch on second write aborts
    wr_full(1'b1, 16'h1234, 1'b0, 16'h1234, 2);
    wr_full(1'b0, 16'h1235, 1'b0, 16'h1235, 3);
    wr_full(1'b1, 16'h1235, 1'b0, 16'h1235, 3);
    wr_full(1'b0, 16'h1235, 1'b0, 16'h1235, 3);
    // R6: mismatch on third write restarts with the new mask; 1,1 also restarts
    wr_full(1'b1, 16'h1236, 1'b0, 16'h1236, 6);
    wr_full(1'b1, 16'h1236, 1'b0, 16'h1236, 6);
    wr_full(1'b0, 16'h1236, 1'b0, 16'h1236, 6);
    // R4: key bit 0 where 1 is due aborts
    wr_full(1'b0, 16'h1236, 1'b0, 16'h1236, 4);
    wr_full(1'b1, 16'h1236, 1'b0, 16'h1236, 4);
    // R5: partial access aborts, so the next key=1 write starts over
    step(1'b1, 4'b0011, 32'h0000_1236, 1'b0, 16'h1236, 5, 32'h0F0F_F0F0);
    wr_full(1'b1, 16'h1236, 1'b0, 16'h1236, 5);
    // R2: idle cycle inside the sequence, then complete it
    step(1'b0, 4'h0, '0, 1'b0, 16'h1236, 2, 32'hDEAD_BEEF);
    wr_full(1'b0, 16'h1236, 1'b0, 16'h1236, 2);
    wr_full(1'b1, 16'h1236, 1'b1, 16'h1236, 2);
    // R8: writes after locking are ignored
    step(1'b1, 4'hF,    32'h0000_FFFF, 1'b1, 16'h1236, 8, 32'hFFFF_FFFF);
    step(1'b1, 4'b0001, 32'h0000_0000, 1'b1, 16'h1236, 8, 32'hC3C3_3C3C);
    step(1'b1, 4'hF,    32'h0001_0000, 1'b1, 16'h1236, 8, 32'h0000_FFFF);
    step(1'b0, 4'h0, '0, 1'b1, 16'h1236, 9, 32'h7777_8888);
    // R10: reset clears the lock
    @(negedge clk); rst_n = 1'b0;
    step(1'b0, 4'h0, '0, 1'b0, 16'h0, 10, 32'hFFFF_FFFF);
    rst_n = 1'b1;
    step(1'b0, 4'h0, '0, 1'b0, 16'h0, 10, 32'hFFFF_FFFF);
    step(1'b0, 4'h0, '0, 1'b0, 16'h0, 10, 32'hFFFF_FFFF);
    step(1'b0, 4'h0, '0, 1'b0, 16'h0, 10, 32'hFFFF_FFFF);
    // R9: lock every pin
    wr_full(1'b1, 16'hFFFF, 1'b0, 16'hFFFF, 2);
    wr_full(1'b0, 16'hFFFF, 1'b0, 16'hFFFF, 2);
    wr_full(1'b1, 16'hFFFF, 1'b1, 16'hFFFF, 2);
    step(1'b0, 4'h0, '0, 1'b1, 16'hFFFF, 9, 32'hFFFF_FFFF);
    step(1'b0, 4'h0, '0, 1'b1, 16'hFFFF, 9, 32'h0000_0000);
    @(negedge clk); lk_wr = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule